// File: doc/BRIEF.md
# Indirect SerDes Control-Register Access Engine

This block gives a host a simple request/response path into the internal control registers of a SerDes PHY. The PHY exposes those registers only through a two-level indirect scheme. A memory-mapped window is paged by a page-select word. Behind the window sit three command registers: control, address and data. Each host request names a lane port, a 16-bit internal address, a direction and, for writes, a data word. The engine turns that request into the full chain of bus operations and raises a one-cycle completion pulse. For reads, the returned word comes with that pulse.

Every command-register access costs two bus operations. The first is a write of the page-select word to window offset 0x800. That word combines the port's device number, taken from a per-port table fixed at build time, with bits [15:9] of the command register's address. The second is the windowed access itself, at the register's low nine address bits times four. Before it hands over an address, the engine polls the control register's busy bit. A read also polls after the start command. A programmable limit on busy polls ends a stuck wait with an error.

Top module: `phy_window_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `done`, `err` and `bus_req` are 0.
- R2: Every windowed access is preceded by a write to bus address 0x800. The data of that write is the port's 5-bit device number times 128 plus bits [15:9] of the command register address. All three command registers give 0x40 for those bits.
- R3: A windowed access uses bus address (internal address mod 512) * 4. This gives 0x280 for control (0x80A0), 0x284 for address (0x80A1) and 0x288 for data (0x80A2).
- R4: A host write runs these steps in order: busy polling, an address-register write of the host address, a data-register write of the host data, and a control write of 0x0003. Bit 0 is start and bit 1 selects write. `done` follows with `err` 0 and `rdata` 0.
- R5: A host read runs these steps in order: busy polling, an address-register write, a control write of 0x0001, busy polling again, and a data-register read. `rdata` carries the word returned by that read in the `done` cycle.
- R6: A busy poll is a control-register read. While its bit 0 is 1 the poll is repeated. At least `POLL_GAP` cycles pass with `bus_req` low between a busy response and the next page-select write.
- R7: Within one polling phase, if the number of busy responses reaches `poll_limit` (sampled at accept; 0 acts as 1), the engine issues no further bus operation. It then raises `done` with `err` 1 and `rdata` 0. A limit one above the number of busy responses still completes normally.
- R8: `req_ready` is 1 only while idle and drops in the cycle after a request is accepted. Requests presented while it is 0 are not taken and cause no bus operations.
- R9: `done` lasts exactly one cycle per request, and `err` is 1 only together with `done`.
- R10: The device number in the page-select word is entry `req_port` of the `DEV_TABLE` parameter, 5 bits per entry, with entry 0 in the least significant bits.
- R11: `bus_req` is high for single cycles, and a new one is issued only after `bus_ack` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_limit | input | LIMIT_W | Busy-response limit per polling phase, sampled at accept |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_port | input | PORT_W | Lane-port index selecting the device number |
| req_addr | input | 16 | PHY-internal register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Data for a write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached, valid with `done` |
| rdata | output | 16 | Read result, valid with `done` |
| bus_req | output | 1 | One-cycle bus operation request |
| bus_we | output | 1 | Bus operation direction, 1 = write |
| bus_addr | output | 12 | Window byte offset |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus operation response |
| bus_rdata | input | 16 | Bus read data, valid with `bus_ack` |

## Verification
The hardest situation to reach from the ports is an abort in the second polling phase of a read. The address and start writes have already gone out, and only then does the busy bit stay stuck. The bench's PHY responder reloads a per-transaction busy count whenever a start command is written, separately from the count used before the first poll. This lets a read pass its first phase cleanly and then stall. Limit boundaries are reached the same way: the busy count is set one below, equal to, and far above `poll_limit`, including a limit of zero.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

  localparam int unsigned IADDR_W = 16;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned BUS_AW  = 12;
  localparam int unsigned DEV_W   = 5;

  // command registers behind the window
  localparam logic [IADDR_W-1:0] REG_CTL = 16'h80A0;
  localparam logic [IADDR_W-1:0] REG_ADR = 16'h80A1;
  localparam logic [IADDR_W-1:0] REG_DAT = 16'h80A2;

  localparam logic [BUS_AW-1:0] PAGE_SEL_OFF = 12'h800;

  localparam logic [DATA_W-1:0] CMD_START_RD = 16'h0001;
  localparam logic [DATA_W-1:0] CMD_START_WR = 16'h0003;

  // device number above the upper seven address bits
  function automatic logic [DATA_W-1:0] page_word(input logic [DEV_W-1:0] dev,
                                                  input logic [IADDR_W-1:0] ia);
    return {4'b0000, dev, ia[15:9]};
  endfunction

  // word-aligned byte offset of the low nine address bits
  function automatic logic [BUS_AW-1:0] win_off(input logic [IADDR_W-1:0] ia);
    return {1'b0, ia[8:0], 2'b00};
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_GAP, S_SETADR, S_SETDAT, S_KICK, S_FETCH
  } seq_t;

  typedef enum logic [2:0] {
    A_IDLE, A_PAGE, A_PAGE_W, A_WIN, A_WIN_W
  } acc_t;

endpackage

// File: rtl/pwe_dev_table.sv
module pwe_dev_table
  import pwe_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 2,
  parameter logic [NUM_PORTS*DEV_W-1:0] DEV_TABLE = '0
) (
  input  logic [PORT_W-1:0] port,
  output logic [DEV_W-1:0]  dev
);

  logic [DEV_W-1:0] entry [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_entry
    assign entry[g] = DEV_TABLE[g*DEV_W +: DEV_W];
  end

  always_comb begin
    dev = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (32'(port) == i) dev = entry[i];
    end
  end

endmodule

// File: rtl/pwe_poll_pacer.sv
module pwe_poll_pacer #(
  parameter int unsigned GAP_CYCLES = 4,
  parameter int unsigned LIMIT_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               busy_hit,
  input  logic [LIMIT_W-1:0] limit,
  output logic               gap_wait,
  output logic               exhausted
);

  localparam int unsigned GAP_W = $clog2(GAP_CYCLES + 1);

  // true when one more busy response reaches the limit (limit 0 acts as 1)
  function automatic logic at_limit(input logic [LIMIT_W-1:0] seen,
                                    input logic [LIMIT_W-1:0] lim);
    logic [LIMIT_W:0] next_seen;
    next_seen = {1'b0, seen} + {{LIMIT_W{1'b0}}, 1'b1};
    return next_seen >= {1'b0, lim};
  endfunction

  logic [LIMIT_W-1:0] busy_seen;
  logic [GAP_W-1:0]   gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_seen <= '0;
      gap_cnt   <= '0;
    end else begin
      if (restart)       busy_seen <= '0;
      else if (busy_hit) busy_seen <= busy_seen + 1'b1;

      if (busy_hit)            gap_cnt <= GAP_W'(GAP_CYCLES);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign gap_wait  = (gap_cnt != '0);
  assign exhausted = at_limit(busy_seen, limit);

  // R6
  gap_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> gap_wait);

endmodule

// File: rtl/pwe_win_access.sv
module pwe_win_access
  import pwe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [DEV_W-1:0]   dev,
  input  logic [IADDR_W-1:0] iaddr,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic               acc_done,
  output logic [DATA_W-1:0]  acc_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata
);

  acc_t               st;
  logic [DEV_W-1:0]   dev_q;
  logic [IADDR_W-1:0] ia_q;
  logic               we_q;
  logic [DATA_W-1:0]  wd_q;
  logic               page_phase;
  logic               win_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= A_IDLE;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
      dev_q     <= '0;
      ia_q      <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
    end else begin
      acc_done <= 1'b0;
      case (st)
        A_IDLE: if (go) begin
          dev_q <= dev;
          ia_q  <= iaddr;
          we_q  <= we;
          wd_q  <= wdata;
          st    <= A_PAGE;
        end
        A_PAGE:   st <= A_PAGE_W;
        A_PAGE_W: if (bus_ack) st <= A_WIN;
        A_WIN:    st <= A_WIN_W;
        A_WIN_W: if (bus_ack) begin
          st        <= A_IDLE;
          acc_done  <= 1'b1;
          acc_rdata <= we_q ? '0 : bus_rdata;
        end
        default: st <= A_IDLE;
      endcase
    end
  end

  always_comb begin
    page_phase = (st == A_PAGE);
    win_phase  = (st == A_WIN);
    bus_req    = page_phase | win_phase;
    bus_we     = page_phase | we_q;
    bus_addr   = page_phase ? PAGE_SEL_OFF : win_off(ia_q);
    bus_wdata  = page_phase ? page_word(dev_q, ia_q) : (we_q ? wd_q : '0);
  end

  // R11
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  // R11
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == A_IDLE));

  // R2
  page_before_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_phase |-> $past(bus_ack));

  // R2
  page_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == PAGE_SEL_OFF) |-> bus_we);

endmodule

// File: rtl/phy_window_engine.sv
module phy_window_engine
  import pwe_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned POLL_GAP  = 4,
  parameter int unsigned LIMIT_W   = 16,
  parameter logic [NUM_PORTS*5-1:0] DEV_TABLE = {5'd22, 5'd9, 5'd17, 5'd4},
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIMIT_W-1:0] poll_limit,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PORT_W-1:0]  req_port,
  input  logic [15:0]        req_addr,
  input  logic               req_write,
  input  logic [15:0]        req_wdata,
  output logic               done,
  output logic               err,
  output logic [15:0]        rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [11:0]        bus_addr,
  output logic [15:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [15:0]        bus_rdata
);

  seq_t               st;
  logic               launched;
  logic               phase2;
  logic [IADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wd_q;
  logic               wr_q;
  logic [DEV_W-1:0]   dev_q;
  logic [LIMIT_W-1:0] limit_q;

  logic [DEV_W-1:0]   port_dev;
  logic               accept;
  logic               in_step;
  logic               go;
  logic [IADDR_W-1:0] step_addr;
  logic               step_we;
  logic [DATA_W-1:0]  step_wd;
  logic               acc_done;
  logic [DATA_W-1:0]  acc_rdata;
  logic               busy_hit;
  logic               restart;
  logic               gap_wait;
  logic               exhausted;

  pwe_dev_table #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .DEV_TABLE (DEV_TABLE)
  ) u_table (
    .port (req_port),
    .dev  (port_dev)
  );

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    in_step   = 1'b1;
    step_addr = REG_CTL;
    step_we   = 1'b0;
    step_wd   = '0;
    case (st)
      S_POLL:   ;
      S_SETADR: begin step_addr = REG_ADR; step_we = 1'b1; step_wd = addr_q; end
      S_SETDAT: begin step_addr = REG_DAT; step_we = 1'b1; step_wd = wd_q;   end
      S_KICK:   begin step_we = 1'b1; step_wd = wr_q ? CMD_START_WR : CMD_START_RD; end
      S_FETCH:  step_addr = REG_DAT;
      default:  in_step = 1'b0;
    endcase
  end

  assign go       = in_step && !launched;
  assign busy_hit = (st == S_POLL) && acc_done && acc_rdata[0];
  assign restart  = accept || ((st == S_KICK) && acc_done && !wr_q);

  pwe_win_access u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .dev       (dev_q),
    .iaddr     (step_addr),
    .we        (step_we),
    .wdata     (step_wd),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  pwe_poll_pacer #(
    .GAP_CYCLES (POLL_GAP),
    .LIMIT_W    (LIMIT_W)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .busy_hit  (busy_hit),
    .limit     (limit_q),
    .gap_wait  (gap_wait),
    .exhausted (exhausted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      launched <= 1'b0;
      phase2   <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      wr_q     <= 1'b0;
      dev_q    <= '0;
      limit_q  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (go)       launched <= 1'b1;
      if (acc_done) launched <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          wr_q    <= req_write;
          dev_q   <= port_dev;
          limit_q <= poll_limit;
          phase2  <= 1'b0;
          st      <= S_POLL;
        end
        S_POLL: if (acc_done) begin
          if (!acc_rdata[0]) begin
            st <= phase2 ? S_FETCH : S_SETADR;
          end else if (exhausted) begin
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
            st    <= S_IDLE;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP:    if (!gap_wait) st <= S_POLL;
        S_SETADR: if (acc_done) st <= wr_q ? S_SETDAT : S_KICK;
        S_SETDAT: if (acc_done) st <= S_KICK;
        S_KICK: if (acc_done) begin
          if (wr_q) begin
            done  <= 1'b1;
            rdata <= '0;
            st    <= S_IDLE;
          end else begin
            phase2 <= 1'b1;
            st     <= S_POLL;
          end
        end
        S_FETCH: if (acc_done) begin
          done  <= 1'b1;
          rdata <= acc_rdata;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R6
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> !bus_req);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7
  no_op_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

endmodule

// File: tb/phy_window_engine_tb.sv
module phy_window_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BENCH_GAP  = 4;

  typedef struct packed {
    logic [1:0]  port;
    logic [15:0] addr;
    logic        wr;
    logic [15:0] wd;
    logic [7:0]  b1;
    logic [7:0]  b2;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd0, 16'h1234, 1'b1, 16'hBEEF, 8'd0, 8'd0},
    '{2'd1, 16'h0007, 1'b0, 16'h0000, 8'd0, 8'd0},
    '{2'd2, 16'hA55A, 1'b1, 16'h0F0F, 8'd2, 8'd0},
    '{2'd3, 16'hFFFF, 1'b0, 16'h0000, 8'd1, 8'd3},
    '{2'd1, 16'h8000, 1'b1, 16'h0001, 8'd3, 8'd0},
    '{2'd0, 16'h01FF, 1'b0, 16'h0000, 8'd3, 8'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] poll_limit;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_port;
  logic [15:0] req_addr;
  logic        req_write;
  logic [15:0] req_wdata;
  logic        done;
  logic        err;
  logic [15:0] rdata;
  logic        bus_req;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  phy_window_engine #(
    .NUM_PORTS (4),
    .POLL_GAP  (BENCH_GAP),
    .LIMIT_W   (16),
    .DEV_TABLE ({5'd22, 5'd9, 5'd17, 5'd4})
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .poll_limit(poll_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- PHY responder and bus log ----------------
  int          busy_left;
  int          kick_busy;
  int          overlap;
  int          cyc_cnt;
  bit          pend;
  logic [6:0]  pg;
  logic [15:0] r_adr;
  int          log_n;
  int          log_a [256];
  int          log_w [256];
  int          log_d [256];
  int          log_r [256];
  int          log_t [256];

  function automatic int bench_dev(input int p);
    case (p)
      0: return 4;
      1: return 17;
      2: return 9;
      default: return 22;
    endcase
  endfunction

  initial begin
    bus_ack = 1'b0; bus_rdata = '0; pend = 0; overlap = 0; cyc_cnt = 0;
    busy_left = 0; kick_busy = 0; log_n = 0; pg = '0; r_adr = '0;
  end

  always @(posedge clk) begin
    int resp;
    int ia;
    cyc_cnt = cyc_cnt + 1;
    if (bus_ack) pend = 0;
    bus_ack <= 1'b0;
    if (rst_n && bus_req) begin
      if (pend) overlap = overlap + 1;
      pend = 1;
      resp = 0;
      if (bus_addr == 12'h800) begin
        if (bus_we) pg = bus_wdata[6:0];
      end else begin
        ia = int'(pg) * 512 + int'(bus_addr) / 4;
        if (bus_we) begin
          if (ia == 32'h80A1) r_adr = bus_wdata;
          if (ia == 32'h80A0 && bus_wdata[0]) busy_left = kick_busy;
        end else if (ia == 32'h80A0) begin
          resp = (busy_left > 0) ? 1 : 0;
          if (busy_left > 0) busy_left = busy_left - 1;
        end else if (ia == 32'h80A2) begin
          resp = int'(r_adr ^ 16'h5A3C);
        end
      end
      if (log_n < 256) begin
        log_a[log_n] = int'(bus_addr);
        log_w[log_n] = int'(bus_we);
        log_d[log_n] = bus_we ? int'(bus_wdata) : 0;
        log_r[log_n] = resp;
        log_t[log_n] = cyc_cnt;
        log_n = log_n + 1;
      end
      bus_ack   <= 1'b1;
      bus_rdata <= 16'(resp);
    end
  end

  // ---------------- expected sequence ----------------
  int exp_n;
  int exp_a [256];
  int exp_w [256];
  int exp_d [256];

  task automatic push(input int a, input int w, input int d);
    if (exp_n < 256) begin
      exp_a[exp_n] = a; exp_w[exp_n] = w; exp_d[exp_n] = d;
      exp_n = exp_n + 1;
    end
  endtask

  // page select then windowed op; all command registers share page 0x40
  task automatic reg_op(input int dev, input int reg_a, input int w, input int d);
    push(32'h800, 1, dev * 128 + reg_a / 512);
    push((reg_a % 512) * 4, w, w ? d : 0);
  endtask

  task automatic poll_phase(input int dev, input int busy, input int lim, output bit aborted);
    int eff;
    eff = (lim == 0) ? 1 : lim;
    aborted = 0;
    for (int k = 0; k <= busy; k++) begin
      reg_op(dev, 32'h80A0, 0, 0);
      if (k < busy && k + 1 >= eff) begin
        aborted = 1;
        break;
      end
      if (k == busy) break;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ---------------- one host transaction ----------------
  task automatic run_txn(input int port, input int addr, input bit wr, input int wd,
                         input int b1, input int b2, input int lim, input bit hold);
    bit ab;
    bit got;
    bit ready_bad;
    int exp_err;
    int exp_rd;
    int dev;
    int first_bad;
    int gap_bad;
    int got_err;
    int got_rd;
    dev = bench_dev(port);
    exp_n = 0; exp_err = 0; exp_rd = 0;
    poll_phase(dev, b1, lim, ab);
    if (ab) exp_err = 1;
    else begin
      reg_op(dev, 32'h80A1, 1, addr);
      if (wr) begin
        reg_op(dev, 32'h80A2, 1, wd);
        reg_op(dev, 32'h80A0, 1, 3);
      end else begin
        reg_op(dev, 32'h80A0, 1, 1);
        poll_phase(dev, b2, lim, ab);
        if (ab) exp_err = 1;
        else begin
          reg_op(dev, 32'h80A2, 0, 0);
          exp_rd = (addr ^ 32'h5A3C) & 32'hFFFF;
        end
      end
    end

    @(negedge clk);
    log_n = 0; overlap = 0;
    busy_left = b1; kick_busy = b2;
    poll_limit = 16'(lim);
    req_port = 2'(port); req_addr = 16'(addr); req_write = wr; req_wdata = 16'(wd);
    req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      req_port = 2'(port + 1); req_addr = 16'h3C3C; req_write = ~wr; req_wdata = 16'h7777;
    end else begin
      req_valid = 1'b0;
    end
    chk(req_ready == 1'b0, "R8", "ready after accept", int'(req_ready), 0);
    got = 0; ready_bad = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
      if (req_ready) ready_bad = 1;
    end
    req_valid = 1'b0;
    got_err = int'(err); got_rd = int'(rdata);
    chk(got, "R4 R5", "done seen", int'(got), 1);
    chk(!ready_bad, "R8", "ready held low while busy", int'(ready_bad), 0);
    chk(got_err == exp_err, "R7", "err flag", got_err, exp_err);
    chk(got_rd == exp_rd, "R5", "rdata", got_rd, exp_rd);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    chk(log_n == exp_n, "R2 R3 R4 R5 R7 R8", "bus op count", log_n, exp_n);
    first_bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (first_bad < 0 && (log_a[i] != exp_a[i] || log_w[i] != exp_w[i] || log_d[i] != exp_d[i]))
        first_bad = i;
    end
    if (first_bad >= 0)
      chk(1'b0, "R2 R3 R10", "bus op addr/data",
          log_a[first_bad] * 65536 + log_d[first_bad], exp_a[first_bad] * 65536 + exp_d[first_bad]);
    else
      chk(1'b1, "R2 R3 R10", "bus op addr/data", 0, 0);
    gap_bad = 0;
    for (int i = 0; i + 1 < log_n; i++) begin
      if (log_a[i] == 32'h280 && log_w[i] == 0 && log_r[i] == 1 &&
          log_t[i+1] - log_t[i] < BENCH_GAP + 1)
        gap_bad = log_t[i+1] - log_t[i];
    end
    chk(gap_bad == 0, "R6", "poll spacing", gap_bad, BENCH_GAP + 1);
    chk(overlap == 0, "R11", "overlapping bus requests", overlap, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 180000);
    n_checks = n_checks + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog R4 R5: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_addr = '0;
    req_write = 1'b0; req_wdata = '0; poll_limit = 16'd8;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(req_ready == 1'b1 && done == 1'b0 && err == 1'b0 && bus_req == 1'b0,
        "R1", "outputs in reset", {req_ready, done, err, bus_req}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    chk(req_ready == 1'b1 && done == 1'b0 && err == 1'b0 && bus_req == 1'b0,
        "R1", "outputs after reset", {req_ready, done, err, bus_req}, 4'b1000);

    // vector table: R2 R3 R4 R5 R6 R10 across ports, directions and busy counts
    for (int v = 0; v < 6; v++) begin
      run_txn(int'(VECS[v].port), int'(VECS[v].addr), VECS[v].wr, int'(VECS[v].wd),
              int'(VECS[v].b1), int'(VECS[v].b2), 8, 1'b0);
    end

    // R7 stuck busy, limit 5
    run_txn(2, 16'h4321, 1'b1, 16'h1111, 20, 0, 5, 1'b0);
    // R7 limit one above busy count completes
    run_txn(3, 16'h0042, 1'b0, 0, 2, 0, 3, 1'b0);
    // R7 limit equal to busy count aborts
    run_txn(3, 16'h0042, 1'b0, 0, 3, 0, 3, 1'b0);
    // R7 limit zero behaves as one
    run_txn(0, 16'h0100, 1'b1, 16'h2222, 4, 0, 0, 1'b0);
    // R7 abort in second polling phase of a read
    run_txn(1, 16'h6001, 1'b0, 0, 0, 9, 2, 1'b0);
    // R8 request held on the port while busy is not taken twice
    run_txn(2, 16'h0ABC, 1'b1, 16'h9999, 1, 0, 8, 1'b1);
    // recovery after abort, R10 with the last port
    run_txn(3, 16'h1FE0, 1'b0, 0, 0, 1, 8, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule